// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block is a bus-master DMA engine. It moves a run of bytes between a device-side byte stream and a set of memory regions. The regions are listed in a descriptor table that software has placed in system memory. A descriptor is two little-endian 32-bit words at consecutive word addresses. The first word is the region's start address. The second word is a control word: bits 15:1 carry the byte count (bit 0 is ignored), and bit 31 flags the final entry. The engine fetches these words itself over its memory master port. The device byte stream and the fetches share that one port, and it keeps at most one read outstanding.

A transfer is requested by giving a byte count and a direction, then pulsing either `start` or `resume`. `start` begins at the table base with no region in hand. `resume` carries on from wherever the previous transfer left the table pointer and the partly used region. `rewind` moves the table pointer back to the base without touching the region state. The walk ends for one of two reasons: the requested count is satisfied, or the table runs out. The table runs out when the final entry has been consumed or when the pointer has passed one 4 KiB page beyond the base. When the walk ends, the engine raises `done` for one cycle, with `complete` telling the two outcomes apart.

Top module: `sg_table_walker`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `mem_valid` and `snk_valid` are all low.
- R2: A descriptor is fetched as two word reads (`mem_word`=1): the region address at the table pointer, then the control word at pointer+4. After the control word the pointer advances by 8. At most one memory read is outstanding at any time.
- R3: The region byte count is control bits 15:1 with bit 0 taken as zero; an odd count in the control word moves one byte less.
- R4: A control word whose bits 15:1 are all zero describes a 65536-byte region.
- R5: Bit 31 of the control word marks the last descriptor. Once that region is used up, no further descriptor is fetched. If bytes are still owed, `done` rises with `complete`=0.
- R6: No descriptor is fetched once the pointer is 4096 or more bytes past the table base. The walk then ends with `complete`=0.
- R7: Bytes go to consecutive addresses from each region's start, moving region by region. Each step is bounded by both the bytes still owed and the bytes left in the region.
- R8: With `to_mem`=1, device bytes from the `src` stream are written to memory in arrival order, one byte per accepted write.
- R9: With `to_mem`=0, memory bytes are read one at a time and presented on the `snk` stream in address order.
- R10: When the owed count reaches zero, `done` pulses for exactly one cycle with `complete`=1.
- R11: `resume` continues in the partly used region without fetching a descriptor, until that region is exhausted.
- R12: `rewind` returns the table pointer to the (word-aligned) table base, so the next fetch reads the first descriptor again.
- R13: `start` drops any partly used region and the last-entry flag, and fetches again from the table base.
- R14: `start`, `resume` and `rewind` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fresh transfer from the table base |
| resume | input | 1 | Begin a transfer continuing the current table position |
| rewind | input | 1 | Move the table pointer back to the base |
| to_mem | input | 1 | 1: device to memory, 0: memory to device |
| table_base | input | AW | Table base address (low two bits ignored) |
| xfer_bytes | input | LEN_W | Bytes requested for this transfer |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| complete | output | 1 | With done: 1 requested count met, 0 table ran out |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | Request is a byte write |
| mem_word | output | 1 | Request is a 32-bit descriptor word read |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response (byte reads use bits 7:0) |
| src_valid | input | 1 | Device byte available |
| src_ready | output | 1 | Device byte taken |
| src_data | input | 8 | Device byte |
| snk_valid | output | 1 | Byte for the device valid |
| snk_data | output | 8 | Byte for the device |

## Verification
The bench targets the corner cases of descriptor decoding. These are an odd control count, which a design that forgot to clear bit 0 would overrun by one byte, and a zero count, which a naive decoder would treat as an empty region and skip to the next descriptor. It checks that the final-entry flag stops the walk, and that a 4 KiB table of short entries is cut off at the page. A design that kept fetching would read past the table and move more than 1024 bytes. It also covers continuing a partly used region, rewinding, and restarting. In each case a wrong design would either fetch when it should not or would put bytes at shifted addresses. The bench also checks that commands arriving mid-transfer change neither the byte count nor the addresses.

// File: rtl/sg_table_walker.sv
module sg_table_walker #(
  parameter int AW         = 32,
  parameter int LEN_W      = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             resume,
  input  logic             rewind,
  input  logic             to_mem,
  input  logic [AW-1:0]    table_base,
  input  logic [LEN_W-1:0] xfer_bytes,
  output logic             busy,
  output logic             done,
  output logic             complete,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic             mem_word,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [7:0]       src_data,
  output logic             snk_valid,
  output logic [7:0]       snk_data
);
  localparam int RL_W = 17;
  localparam logic [RL_W-1:0] FULL_REGION = RL_W'(65536);
  localparam logic [AW-1:0]   PAGE_LIM    = AW'(PAGE_BYTES);
  localparam logic [AW-1:0]   DESC_STEP   = AW'(8);
  localparam logic [AW-1:0]   CTRL_OFS    = AW'(4);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_AREQ, S_AWAIT, S_CREQ, S_CWAIT, S_WR, S_RREQ, S_RWAIT
  } st_t;

  st_t              st;
  logic [AW-1:0]    base_q, ptr_q, raddr_q;
  logic [RL_W-1:0]  rlen_q;
  logic [LEN_W-1:0] rem_q;
  logic             last_q, dir_q, done_q, ok_q;

  logic [AW-1:0]    tbase_al;
  logic [RL_W-1:0]  dec_len;
  logic             page_out, byte_fire, keep_going;

  assign tbase_al   = {table_base[AW-1:2], 2'b00};
  assign page_out   = (ptr_q - base_q) >= PAGE_LIM;
  assign dec_len    = (mem_rdata[15:1] == 15'd0) ? FULL_REGION
                                                 : {1'b0, mem_rdata[15:1], 1'b0};
  assign byte_fire  = (st == S_WR && src_valid && mem_ready) ||
                      (st == S_RWAIT && mem_rvalid);
  assign keep_going = (rem_q > LEN_W'(1)) && (rlen_q > RL_W'(1));

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign complete  = ok_q;
  assign mem_valid = (st == S_AREQ) || (st == S_CREQ) || (st == S_RREQ) ||
                     (st == S_WR && src_valid);
  assign mem_write = (st == S_WR);
  assign mem_word  = (st == S_AREQ) || (st == S_CREQ);
  assign mem_addr  = (st == S_AREQ) ? ptr_q :
                     (st == S_CREQ) ? ptr_q + CTRL_OFS : raddr_q;
  assign mem_wdata = src_data;
  assign src_ready = (st == S_WR) && mem_ready;
  assign snk_valid = (st == S_RWAIT) && mem_rvalid;
  assign snk_data  = mem_rdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      ptr_q   <= '0;
      raddr_q <= '0;
      rlen_q  <= '0;
      rem_q   <= '0;
      last_q  <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            base_q  <= tbase_al;
            ptr_q   <= tbase_al;
            raddr_q <= '0;
            rlen_q  <= '0;
            last_q  <= 1'b0;
            rem_q   <= xfer_bytes;
            dir_q   <= to_mem;
            st      <= S_CHECK;
          end else begin
            if (rewind) begin
              base_q <= tbase_al;
              ptr_q  <= tbase_al;
            end
            if (resume) begin
              rem_q <= xfer_bytes;
              dir_q <= to_mem;
              st    <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          if (rem_q == '0) begin
            done_q <= 1'b1;
            ok_q   <= 1'b1;
            st     <= S_IDLE;
          end else if (rlen_q != '0) begin
            st <= dir_q ? S_WR : S_RREQ;
          end else if (last_q || page_out) begin
            done_q <= 1'b1;
            ok_q   <= 1'b0;
            st     <= S_IDLE;
          end else begin
            st <= S_AREQ;
          end
        end
        S_AREQ:  if (mem_ready) st <= S_AWAIT;
        S_AWAIT: if (mem_rvalid) begin
          raddr_q <= AW'(mem_rdata);
          st      <= S_CREQ;
        end
        S_CREQ:  if (mem_ready) st <= S_CWAIT;
        S_CWAIT: if (mem_rvalid) begin
          rlen_q <= dec_len;
          last_q <= mem_rdata[31];
          ptr_q  <= ptr_q + DESC_STEP;
          st     <= S_CHECK;
        end
        S_WR:    if (src_valid && mem_ready) st <= keep_going ? S_WR : S_CHECK;
        S_RREQ:  if (mem_ready) st <= S_RWAIT;
        S_RWAIT: if (mem_rvalid) st <= keep_going ? S_RREQ : S_CHECK;
        default: st <= S_IDLE;
      endcase
      if (byte_fire) begin
        raddr_q <= raddr_q + AW'(1);
        rlen_q  <= rlen_q - RL_W'(1);
        rem_q   <= rem_q - LEN_W'(1);
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (complete == (rem_q == '0)));

  // R6
  fetch_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_word) |-> (mem_addr[1:0] == 2'b00 && (mem_addr - base_q) < PAGE_LIM));

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_write) |=> !mem_valid);

  // R7
  byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire |-> (rlen_q != '0 && rem_q != '0));

  // R14
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !snk_valid && !src_ready));
endmodule

// File: tb/sim_sg_table_walker.sv
module sim_sg_table_walker;
  localparam logic [31:0] TB = 32'h2000_0000;
  localparam int NV = 7;
  localparam logic        V_DIR   [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int          V_LEN   [NV] = '{10, 20, 9, 30, 12, 5, 20};
  localparam logic [31:0] V_C0    [NV] = '{32'h8000_000A, 32'h0000_0007, 32'h0000_0005,
                                          32'h8000_000C, 32'h0000_0004, 32'h8000_0001,
                                          32'h0000_0003};
  localparam logic [31:0] V_C1    [NV] = '{32'h8000_0002, 32'h8000_0010, 32'h8000_0008,
                                          32'h8000_0002, 32'h0000_0004, 32'h8000_0002,
                                          32'h8000_0006};
  localparam logic [31:0] V_C2    [NV] = '{32'h8000_0002, 32'h8000_0002, 32'h8000_0002,
                                          32'h8000_0002, 32'h8000_0004, 32'h8000_0002,
                                          32'h8000_0002};
  localparam logic        V_STALL [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam string       V_TAG   [NV] = '{"R8", "R3", "R9", "R5", "R7", "R4", "R9"};

  logic        clk = 0, rst_n = 0;
  logic        start = 0, resume = 0, rewind = 0, to_mem = 0;
  logic [31:0] table_base = TB;
  logic [23:0] xfer_bytes = '0;
  logic        busy, done, complete;
  logic        mem_valid, mem_write, mem_word;
  logic        mem_ready = 1'b1, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [7:0]  mem_wdata, snk_data;
  logic        src_valid = 1'b1, src_ready, snk_valid;
  logic [7:0]  src_data = 8'h33;

  sg_table_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .rewind(rewind),
    .to_mem(to_mem), .table_base(table_base), .xfer_bytes(xfer_bytes),
    .busy(busy), .done(done), .complete(complete),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .snk_valid(snk_valid), .snk_data(snk_data));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] dctl [3];
  bit fill_mode = 0, stall = 0;
  int mk = 0, moff = 0, nbytes = 0, nfetch = 0, merr = 0, max_foff = 0, sndcnt = 0;
  logic [31:0] exp_fetch = TB;
  bit pend = 0, pend_word = 0, wr_adv = 0;
  logic [31:0] pend_addr = '0;
  bit got_ok, pulse_ok;

  function automatic int dec_len(input logic [31:0] c);
    int l = int'(c[15:0] & 16'hFFFE);
    return (l == 0) ? 65536 : l;
  endfunction
  function automatic logic [31:0] reg_base(input int k);
    return fill_mode ? 32'h4000_0000 + 32'(k * 16) : 32'h0001_0000 * 32'(k + 1) + 32'h20;
  endfunction
  function automatic int reg_len(input int k);
    return fill_mode ? 2 : (k < 3 ? dec_len(dctl[k]) : 2);
  endfunction
  function automatic logic [31:0] tword(input logic [31:0] a);
    int idx = int'((a - TB) >> 2);
    if (idx % 2 == 0) return reg_base(idx / 2);
    if (fill_mode) return 32'h0000_0002;
    return (idx / 2 < 3) ? dctl[idx / 2] : 32'h8000_0002;
  endfunction
  function automatic logic [7:0] rpat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] wpat(input int n);
    return 8'(n) ^ 8'h33;
  endfunction
  function automatic logic [31:0] ea();
    return reg_base(mk) + 32'(moff);
  endfunction

  task automatic advance();
    nbytes++;
    moff++;
    if (moff == reg_len(mk)) begin mk++; moff = 0; end
  endtask

  // memory model and byte monitor, all away from the rising edge
  always @(negedge clk) begin
    if (wr_adv) begin sndcnt++; src_data = wpat(sndcnt); wr_adv = 0; end
    if (pend) begin
      mem_rvalid = 1'b1;
      mem_rdata  = pend_word ? tword(pend_addr) : {24'h0, rpat(pend_addr)};
      pend = 0;
    end else mem_rvalid = 1'b0;
    mem_ready = stall ? ~mem_ready : 1'b1;
    #1;
    if (snk_valid) begin
      if (snk_data != rpat(ea())) merr++;
      advance();
    end
    if (mem_valid && mem_ready) begin
      if (mem_word) begin
        if (mem_write || mem_addr != exp_fetch) merr++;
        if (int'(mem_addr - TB) > max_foff) max_foff = int'(mem_addr - TB);
        exp_fetch += 4;
        nfetch++;
        pend = 1; pend_word = 1; pend_addr = mem_addr;
      end else if (mem_write) begin
        if (mem_addr != ea() || mem_wdata != wpat(sndcnt)) merr++;
        wr_adv = 1;
        advance();
      end else begin
        if (mem_addr != ea()) merr++;
        pend = 1; pend_word = 0; pend_addr = mem_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_op(input bit fresh, input bit dir, input int len);
    @(negedge clk);
    nbytes = 0; nfetch = 0; merr = 0; max_foff = 0;
    sndcnt = 0; src_data = wpat(0);
    if (fresh) begin mk = 0; moff = 0; exp_fetch = TB; end
    to_mem = dir; xfer_bytes = 24'(len);
    if (fresh) start = 1; else resume = 1;
    @(negedge clk);
    start = 0; resume = 0;
    while (!done) @(negedge clk);
    got_ok = complete;
    @(negedge clk);
    pulse_ok = !done;
  endtask

  task automatic model(input int len, output int eb, output bit ec, output int ed);
    int rem = len;
    eb = 0; ec = 0; ed = 0;
    for (int k = 0; k < 3; k++) begin
      int t;
      ed++;
      t = (reg_len(k) < rem) ? reg_len(k) : rem;
      eb += t; rem -= t;
      if (rem == 0) begin ec = 1; return; end
      if (dctl[k][31]) return;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R10 watchdog: actual no done, expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int eb, ed;
    bit ec;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy in reset", busy, 0);
    chk(!done, "R1 done in reset", done, 0);
    chk(!mem_valid && !snk_valid, "R1 bus idle in reset", mem_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      dctl[0] = V_C0[v]; dctl[1] = V_C1[v]; dctl[2] = V_C2[v];
      stall = V_STALL[v];
      model(V_LEN[v], eb, ec, ed);
      run_op(1, V_DIR[v], V_LEN[v]);
      stall = 0;
      chk(got_ok == ec, {V_TAG[v], " R10 complete flag"}, got_ok, ec);
      chk(nbytes == eb, {V_TAG[v], " R7 byte count"}, nbytes, eb);
      chk(nfetch == 2 * ed, {V_TAG[v], " R2 descriptor word fetches"}, nfetch, 2 * ed);
      chk(merr == 0, {V_TAG[v], " R3 R7 address/data order"}, merr, 0);
      chk(pulse_ok, "R10 done single cycle", !pulse_ok, 0);
    end

    // R4 zero count region moves 65536 bytes
    dctl[0] = 32'h8000_0000; dctl[1] = 32'h8000_0002; dctl[2] = 32'h8000_0002;
    run_op(1, 1, 70000);
    chk(nbytes == 65536, "R4 zero count bytes", nbytes, 65536);
    chk(!got_ok, "R4 R5 incomplete after last", got_ok, 0);
    chk(merr == 0, "R4 address order", merr, 0);

    // R6 page cap on an endless table of 2-byte regions
    fill_mode = 1;
    run_op(1, 1, 2000);
    chk(nbytes == 1024, "R6 bytes before cap", nbytes, 1024);
    chk(nfetch == 1024, "R6 word fetches", nfetch, 1024);
    chk(max_foff == 4092, "R6 highest fetch offset", max_foff, 4092);
    chk(!got_ok, "R6 incomplete", got_ok, 0);
    chk(merr == 0, "R6 address order", merr, 0);
    fill_mode = 0;

    // R11 resume inside a partly used region
    dctl[0] = 32'h8000_000A;
    run_op(1, 1, 3);
    chk(got_ok && nbytes == 3, "R11 first part", nbytes, 3);
    run_op(0, 1, 4);
    chk(nfetch == 0, "R11 no fetch on resume", nfetch, 0);
    chk(nbytes == 4 && merr == 0, "R11 continues at offset 3", merr, 0);
    chk(got_ok, "R11 complete", got_ok, 1);
    run_op(0, 0, 10);
    chk(nbytes == 3 && nfetch == 0, "R11 R5 rest of last region", nbytes, 3);
    chk(!got_ok && merr == 0, "R11 R5 incomplete", got_ok, 0);

    // R12 rewind
    dctl[0] = 32'h0000_0006; dctl[1] = 32'h8000_0008;
    run_op(1, 0, 6);
    chk(got_ok && nfetch == 2, "R12 setup", nfetch, 2);
    @(negedge clk); rewind = 1; table_base = TB;
    @(negedge clk); rewind = 0;
    mk = 0; moff = 0; exp_fetch = TB;
    run_op(0, 0, 3);
    chk(nfetch == 2 && merr == 0, "R12 refetch from base", merr, 0);
    chk(got_ok && nbytes == 3, "R12 bytes", nbytes, 3);

    // R13 start clears a partly used region
    dctl[0] = 32'h8000_000A;
    run_op(1, 1, 3);
    run_op(1, 1, 4);
    chk(nfetch == 2, "R13 refetch on start", nfetch, 2);
    chk(merr == 0 && nbytes == 4 && got_ok, "R13 bytes from region start", merr, 0);

    // R14 commands while busy are ignored
    @(negedge clk);
    nbytes = 0; nfetch = 0; merr = 0; sndcnt = 0; src_data = wpat(0);
    mk = 0; moff = 0; exp_fetch = TB;
    src_valid = 0; to_mem = 1; xfer_bytes = 24'd10; start = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk(busy, "R14 busy while source stalls", busy, 1);
    start = 1; resume = 1; rewind = 1; xfer_bytes = 24'd3; table_base = TB + 32'h100;
    @(negedge clk); start = 0; resume = 0; rewind = 0; table_base = TB;
    src_valid = 1;
    while (!done) @(negedge clk);
    got_ok = complete;
    @(negedge clk);
    chk(nbytes == 10 && got_ok, "R14 count unchanged", nbytes, 10);
    chk(nfetch == 2 && merr == 0, "R14 addresses unchanged", merr, 0);
    repeat (4) @(negedge clk);
    chk(!busy, "R14 no stray transfer", busy, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule